// File: doc/BRIEF.md
# I2C Register Target with Staged Writes

This block lets an external I2C master read and write a bank of byte-wide registers inside the chip. After its 7-bit address, the master sends a 16-bit register offset. Data bytes then move between the bus and consecutive registers. The target never stretches SCL. It samples SCL and SDA with the system clock and pulls SDA low through an open-drain enable.

Writes are not applied while they arrive. Accepted data bytes collect in a small shadow buffer. When the master sends STOP, all of them land in the register file in the same clock cycle, and a one-cycle commit pulse marks that cycle. A read can follow an offset write through a repeated start, or it can start directly at the internal pointer, which keeps its value between transfers.

The serial pins carry no handshake. SCL paces every bit and the target never holds the bus back, so there is no back-pressure at this edge. Every pin is a plain level. The register contents are exposed as one flat vector for the surrounding logic.

Top module: `i2c_regslave`

## Requirements
- R1: The target answers only to address {cfg_addr_i[6:2], strap_i[1:0]}. A byte carrying any other address gets no ACK, and the target leaves SDA released until the next START.
- R2: After a write address, the next two bytes form the offset, high byte first. Each following data byte goes to the next higher offset, bits MSB first. Register index = offset modulo REG_DEPTH.
- R3: No register changes before STOP. On STOP, every accepted byte of the block is written in one cycle, and commit_o is high in exactly that cycle, for one cycle.
- R4: The shadow buffer holds STAGE_DEPTH bytes (default 16). Later data bytes in the same block get no ACK and are dropped.
- R5: A START or repeated start before STOP discards the staged bytes and any partly received byte. No register changes and commit_o stays low.
- R6: In a read, the target drives the byte at the pointer, MSB first. After a master ACK it drives the next register. After a master NACK it releases SDA.
- R7: The pointer is set by the offset and advances by one for every byte read or every data byte accepted. A read address with no offset phase starts at the pointer.
- R8: After reset, register i holds i XOR 8'hC3, the pointer is 0, SDA is released and commit_o is low.
- R9: sda_oe_o changes only while SCL is low. The target drives ACK in the ninth clock of an accepted byte.
- R10: Transfers work at 100 kHz and at 400 kHz SCL with a 200 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| cfg_addr_i | input | 7 | Configured device address; its two low bits are ignored |
| strap_i | input | 2 | Strap levels that form the two low address bits |
| sda_oe_o | output | 1 | High pulls SDA low |
| reg_q_o | output | REG_DEPTH*8 | Register file contents, register i at bits [8i+7:8i] |
| commit_o | output | 1 | One-cycle pulse when staged bytes are applied |

## Verification
A wrong shadow count or base offset shows up at reg_q_o in the cycle after STOP. The wrong bytes land, the wrong registers change, or a NACK comes early or late in the ninth clock of the byte concerned. A pointer that has drifted shows up in the first byte of the next read, which may come several transfers later, so each read is compared against a model that tracks the pointer across transfers. A shift register or bit counter that is out of step breaks the ACK slot of the same byte, and the master sees it within one byte time.

// File: rtl/i2c_rs_pkg.sv
`timescale 1ns/1ps
package i2c_rs_pkg;
  localparam int OFF_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFH,
    ST_OFFL,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_rs_sync.sv
`timescale 1ns/1ps
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_s;
      sda_q     <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rs_stage.sv
`timescale 1ns/1ps
module i2c_rs_stage
  import i2c_rs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          base_set,
  input  logic [OFF_W-1:0]              base_in,
  input  logic                          push,
  input  logic [BYTE_W-1:0]             push_data,
  output logic                          full,
  output logic [CNT_W-1:0]              cnt,
  output logic [OFF_W-1:0]              base,
  output logic [DEPTH-1:0][BYTE_W-1:0]  data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      base <= '0;
      data <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (base_set) begin
      base <= base_in;
      cnt  <= '0;
    end else if (push && !full) begin
      data[cnt[$clog2(DEPTH)-1:0]] <= push_data;
      cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/i2c_rs_regfile.sv
`timescale 1ns/1ps
module i2c_rs_regfile
  import i2c_rs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int STAGE = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(STAGE + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [IDX_W-1:0]              base_idx,
  input  logic [CNT_W-1:0]              stg_cnt,
  input  logic [STAGE-1:0][BYTE_W-1:0]  stg_data,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [DEPTH*BYTE_W-1:0]       flat_q,
  output logic                          commit_q
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BYTE_W'(i) ^ 8'hC3;
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit;
      if (commit) begin
        for (int i = 0; i < STAGE; i++) begin
          if (CNT_W'(i) < stg_cnt) mem[base_idx + IDX_W'(i)] <= stg_data[i];
        end
      end
    end
  end

  assign rd_data = mem[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat_q[g*BYTE_W +: BYTE_W] = mem[g];
  end
endmodule

// File: rtl/i2c_rs_core.sv
`timescale 1ns/1ps
module i2c_rs_core
  import i2c_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              stg_full,
  output logic              sda_oe,
  output logic [OFF_W-1:0]  ptr,
  output logic              stg_push,
  output logic [BYTE_W-1:0] stg_wdata,
  output logic              stg_base_set
);
  bus_st_e           st, nxt;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] sh, tx, off_hi;
  logic              mack;
  logic              rx_phase;

  assign rx_phase = (st == ST_ADDR) || (st == ST_OFFH) ||
                    (st == ST_OFFL) || (st == ST_WDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      nxt          <= ST_IDLE;
      bitcnt       <= '0;
      sh           <= '0;
      tx           <= '0;
      off_hi       <= '0;
      mack         <= 1'b0;
      sda_oe       <= 1'b0;
      ptr          <= '0;
      stg_push     <= 1'b0;
      stg_wdata    <= '0;
      stg_base_set <= 1'b0;
    end else begin
      stg_push     <= 1'b0;
      stg_base_set <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (rx_phase) begin
        if (scl_rise) begin
          sh     <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          st <= ST_ACK;
          unique case (st)
            ST_ADDR: begin
              if (sh[7:1] == dev_addr) begin
                sda_oe <= 1'b1;
                nxt    <= sh[0] ? ST_RDATA : ST_OFFH;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_OFFH: begin
              off_hi <= sh;
              sda_oe <= 1'b1;
              nxt    <= ST_OFFL;
            end
            ST_OFFL: begin
              ptr          <= {off_hi, sh};
              stg_base_set <= 1'b1;
              sda_oe       <= 1'b1;
              nxt          <= ST_WDATA;
            end
            default: begin
              nxt <= ST_WDATA;
              if (!stg_full) begin
                stg_push  <= 1'b1;
                stg_wdata <= sh;
                ptr       <= ptr + 1'b1;
                sda_oe    <= 1'b1;
              end
            end
          endcase
        end
      end else begin
        unique case (st)
          ST_ACK: if (scl_fall) begin
            bitcnt <= '0;
            st     <= nxt;
            if (nxt == ST_RDATA) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
          ST_RDATA: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              st     <= ST_RACK;
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= ST_RDATA;
                bitcnt <= '0;
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regslave.sv
`timescale 1ns/1ps
module i2c_regslave
  import i2c_rs_pkg::*;
#(
  parameter int REG_DEPTH   = 32,
  parameter int STAGE_DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  input  logic [6:0]                  cfg_addr_i,
  input  logic [1:0]                  strap_i,
  output logic                        sda_oe_o,
  output logic [REG_DEPTH*BYTE_W-1:0] reg_q_o,
  output logic                        commit_o
);
  localparam int IDX_W = $clog2(REG_DEPTH);
  localparam int CNT_W = $clog2(STAGE_DEPTH + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [OFF_W-1:0] ptr, stg_base;
  logic [BYTE_W-1:0] rd_data, stg_wdata;
  logic stg_push, stg_base_set, stg_full, commit_req;
  logic [CNT_W-1:0] stg_cnt;
  logic [STAGE_DEPTH-1:0][BYTE_W-1:0] stg_data;
  logic [6:0] dev_addr;

  assign dev_addr   = {cfg_addr_i[6:2], strap_i};
  assign commit_req = stop_det && (stg_cnt != '0);

  i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rs_core u_core (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .dev_addr(dev_addr), .rd_data(rd_data), .stg_full(stg_full),
    .sda_oe(sda_oe_o), .ptr(ptr), .stg_push(stg_push),
    .stg_wdata(stg_wdata), .stg_base_set(stg_base_set)
  );

  i2c_rs_stage #(.DEPTH(STAGE_DEPTH)) u_stage (
    .clk(clk), .rst_n(rst_n), .clear(start_det | stop_det),
    .base_set(stg_base_set), .base_in(ptr), .push(stg_push),
    .push_data(stg_wdata), .full(stg_full), .cnt(stg_cnt),
    .base(stg_base), .data(stg_data)
  );

  i2c_rs_regfile #(.DEPTH(REG_DEPTH), .STAGE(STAGE_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit_req),
    .base_idx(stg_base[IDX_W-1:0]), .stg_cnt(stg_cnt), .stg_data(stg_data),
    .rd_idx(ptr[IDX_W-1:0]), .rd_data(rd_data), .flat_q(reg_q_o),
    .commit_q(commit_o)
  );
endmodule

// File: rtl/i2c_regslave_chk.sv
`timescale 1ns/1ps
module i2c_regslave_chk #(
  parameter int REG_DEPTH   = 32,
  parameter int STAGE_DEPTH = 16,
  localparam int CNT_W = $clog2(STAGE_DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_i,
  input logic                   sda_oe_o,
  input logic                   commit_o,
  input logic [REG_DEPTH*8-1:0] reg_q_o,
  input logic                   stop_det,
  input logic [CNT_W-1:0]       stg_cnt
);
  p_regs_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |-> $stable(reg_q_o));

  p_commit_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_det));

  p_commit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stg_cnt <= CNT_W'(STAGE_DEPTH));

  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_regslave i2c_regslave_chk #(
  .REG_DEPTH(REG_DEPTH), .STAGE_DEPTH(STAGE_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .commit_o(commit_o), .reg_q_o(reg_q_o), .stop_det(stop_det),
  .stg_cnt(stg_cnt)
);

// File: tb/sim_i2c_regslave.sv
`timescale 1ns/1ps
module sim_i2c_regslave;
  localparam int DEPTH  = 32;
  localparam int STG    = 4;
  localparam int Q_FAST = 125;   // 400 kHz at 200 MHz
  localparam int Q_SLOW = 500;   // 100 kHz at 200 MHz
  localparam int WD     = 195000;

  typedef struct { logic [7:0] v; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] cfg = 7'h52;
  logic [1:0] strap = 2'b01;   // device address 7'h51
  wire sda_oe, commit;
  wire [DEPTH*8-1:0] regq;
  wire sda_line = sda_m & ~sda_oe;

  int q = Q_FAST;
  int nvec = 0, nbad = 0, ncommit = 0, nchg = 0, bad_oe = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  exp_t exp_q[$];
  logic [7:0] got_q[$];

  always #2.5 clk = ~clk;

  i2c_regslave #(.REG_DEPTH(DEPTH), .STAGE_DEPTH(STG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .cfg_addr_i(cfg), .strap_i(strap), .sda_oe_o(sda_oe),
    .reg_q_o(regq), .commit_o(commit)
  );

  function automatic logic [7:0] rv(int i);
    return 8'(i) ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (regq[i*8 +: 8] !== model[i] && bad < 0) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " reg"}, {24'(bad), regq[bad*8 +: 8]}, {24'(bad), model[bad]});
  endtask

  // monitors on the falling edge
  logic [DEPTH*8-1:0] regq_prev;
  logic oe_prev = 1'b0;
  initial begin
    @(posedge rst_n);
    regq_prev = regq;
    forever begin
      @(negedge clk);
      if (commit === 1'b1) ncommit++;
      if (regq !== regq_prev) nchg++;
      if (sda_oe !== oe_prev && scl_m === 1'b1) bad_oe++;
      regq_prev = regq;
      oe_prev = sda_oe;
    end
  end

  // scoreboard: compare read bytes with expected items
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g;
        exp_t e;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", 32'(g), 0);
        else begin
          e = exp_q.pop_front();
          chk(g === e.v, e.tag, 32'(g), 32'(e.v));
        end
      end
    end
  end

  task automatic wait_q();
    repeat (q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic wr_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    ack = ~sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic rd_byte(logic mack);
    logic [7:0] v;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_m = 1'b1; wait_q();
      v[i] = sda_line; wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = ~mack; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
    sda_m = 1'b1;
    got_q.push_back(v);
  endtask

  task automatic expect_rd(logic [7:0] v, string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr_chk(logic [7:0] v, logic exp_ack, string tag);
    logic a;
    wr_byte(v, a);
    chk(a === exp_ack, tag, 32'(a), 32'(exp_ack));
  endtask

  // watchdog
  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", WD, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int c0, g0;
    for (int i = 0; i < DEPTH; i++) model[i] = rv(i);
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8: reset state
    chk(sda_oe === 1'b0, "R8 sda released", 32'(sda_oe), 0);
    chk(commit === 1'b0, "R8 commit low", 32'(commit), 0);
    chk_regs("R8 reset values");

    // R2/R3: block write of three bytes at offset 0x0004
    bus_start();
    wr_chk(8'hA2, 1'b1, "R1 address ack");
    wr_chk(8'h00, 1'b1, "R2 offset high ack");
    wr_chk(8'h04, 1'b1, "R2 offset low ack");
    wr_chk(8'h11, 1'b1, "R2 data ack");
    wr_chk(8'h22, 1'b1, "R2 data ack");
    wr_chk(8'h33, 1'b1, "R2 data ack");
    chk_regs("R3 unchanged before stop");
    c0 = ncommit; g0 = nchg;
    bus_stop();
    repeat (10) @(negedge clk);
    model[4] = 8'h11; model[5] = 8'h22; model[6] = 8'h33;
    chk_regs("R2 ascending write");
    chk(ncommit - c0 == 1, "R3 one commit pulse", 32'(ncommit - c0), 1);
    chk(nchg - g0 == 1, "R3 single update cycle", 32'(nchg - g0), 1);

    // R6: sequential read from offset 0x0005
    bus_start();
    wr_chk(8'hA2, 1'b1, "R6 address ack");
    wr_chk(8'h00, 1'b1, "R6 offset high ack");
    wr_chk(8'h05, 1'b1, "R6 offset low ack");
    bus_rstart();
    wr_chk(8'hA3, 1'b1, "R6 read address ack");
    expect_rd(8'h22, "R6 first byte");
    rd_byte(1'b1);
    expect_rd(8'h33, "R6 after ack");
    rd_byte(1'b1);
    expect_rd(rv(7), "R6 last byte");
    rd_byte(1'b0);
    chk(sda_oe === 1'b0, "R6 released after nack", 32'(sda_oe), 0);
    bus_stop();

    // R7/R10: current read at 100 kHz from pointer 8
    q = Q_SLOW;
    bus_start();
    wr_chk(8'hA3, 1'b1, "R10 slow address ack");
    expect_rd(rv(8), "R7 current read");
    rd_byte(1'b0);
    bus_stop();
    q = Q_FAST;

    // R1: raw configured address is not ours once straps replace bits
    bus_start();
    wr_chk(8'hA4, 1'b0, "R1 foreign address nack");
    chk(sda_oe === 1'b0, "R1 no drive", 32'(sda_oe), 0);
    bus_stop();

    // R4: overflow of the shadow buffer, offset 0x011E wraps to 30
    bus_start();
    wr_chk(8'hA2, 1'b1, "R4 address ack");
    wr_chk(8'h01, 1'b1, "R4 offset high ack");
    wr_chk(8'h1E, 1'b1, "R4 offset low ack");
    wr_chk(8'hA1, 1'b1, "R4 data ack");
    wr_chk(8'hA2, 1'b1, "R4 data ack");
    wr_chk(8'hA3, 1'b1, "R4 data ack");
    wr_chk(8'hA4, 1'b1, "R4 data ack");
    wr_chk(8'hA5, 1'b0, "R4 overflow nack");
    bus_stop();
    repeat (10) @(negedge clk);
    model[30] = 8'hA1; model[31] = 8'hA2; model[0] = 8'hA3; model[1] = 8'hA4;
    chk_regs("R4 wrap and drop");

    // R5: staged byte and partial byte discarded by repeated start
    c0 = ncommit;
    bus_start();
    wr_chk(8'hA2, 1'b1, "R5 address ack");
    wr_chk(8'h00, 1'b1, "R5 offset high ack");
    wr_chk(8'h10, 1'b1, "R5 offset low ack");
    wr_chk(8'h77, 1'b1, "R5 data ack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_rstart();
    wr_chk(8'hA3, 1'b1, "R5 read address ack");
    expect_rd(rv(17), "R7 pointer after staged byte");
    rd_byte(1'b0);
    bus_stop();
    repeat (10) @(negedge clk);
    chk_regs("R5 staged data dropped");
    chk(ncommit == c0, "R5 no commit", 32'(ncommit - c0), 0);

    // R9: enable never moved while SCL was high
    chk(bad_oe == 0, "R9 sda enable timing", 32'(bad_oe), 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule